// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Controller

This block merges three analog-side event sources into one shared interrupt for a small 8-bit processor core. Two sources are amplifier outputs and one is a comparator output. Each source first crosses a two-flop synchronizer. An edge detector then looks for a high-to-low change on an amplifier output and for either direction of change on the comparator. A detected event sets the pending flag of that source and also sets one group request flag that all three share.

The controller asks the core for a vectored call only when four things are true: software has enabled interrupts globally, the group is enabled, the group request is pending and the return stack has room. When it takes the call, the controller clears the group request and the global enable itself, so that the handler runs with further interrupts masked. The three per-source flags stay set, so the handler can read them to find out which sources fired. Software clears them later by writing the source register. Only the program counter is saved on the call, and the core does that. The controller also raises a wake-up output whenever a request is pending while the core is in idle or sleep.

Software sees two 3-bit registers through a single-cycle write port and a combinational read port.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A high-to-low change on amplifier input k (`amp_in[k]`) sets source flag bit k and the group request flag. The input is sampled at clock edge n and the flags read set after clock edge n+2.
- R2: A low-to-high change on an amplifier input sets no flag.
- R3: A change in either direction on `cmp_in` sets source flag bit 2 and the group request flag, with the same latency as R1.
- R4: `call_req` rises in the cycle after a clock edge at which global enable, group enable and group request were all 1 and `stack_full` was 0. No call is made if any one of these conditions is missing.
- R5: While `call_req` is high, `call_vec` holds the service address 0x18.
- R6: Taking a call clears the group request flag and the global enable at the same clock edge. `call_req` is a one-cycle pulse. The clear wins over a software write to the control register in that same cycle.
- R7: A call does not change the source flags. Only a write to the source register changes them.
- R8: A group request stays pending while either enable is 0. It is serviced once both enables are set.
- R9: `wake` is high whenever `sleep_mode` is high and either the group request or any source flag is set.
- R10: When a software write clears a flag in the same cycle that a hardware event sets it, the flag ends up set.
- R11: Register map. Address 0 is the control register: bit0 is the global enable, bit1 the group enable, bit2 the group request. Address 1 is the source register: bit0 is amplifier 0, bit1 amplifier 1, bit2 the comparator. All of these bits read 0 after reset, and a write stores the written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| amp_in | input | 2 | Amplifier outputs (asynchronous) |
| cmp_in | input | 1 | Comparator output (asynchronous) |
| stack_full | input | 1 | Return stack has no free entry |
| sleep_mode | input | 1 | Core is in idle or sleep |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select (0 control, 1 source) |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data for `reg_addr` |
| call_req | output | 1 | One-cycle vectored call strobe to the core |
| call_vec | output | 8 | Service vector address |
| wake | output | 1 | Wake-up request to the core |

## Verification
The hardest case to reach from the ports is a software clear and a hardware event landing in the same cycle. An input change takes three register stages to reach the flags, so the bench changes an amplifier input and then issues the clearing write exactly two falling clock edges later. The stack-full block and the masked-pending cases are reached by first letting a request go pending and then releasing the stack condition or the enable. A behavioural model checks every clock, so the call pulse and the flag clears are compared in the cycle they happen.

// File: rtl/grp_irq_pkg.sv
// Shared constants and types for the grouped interrupt controller.
// Assumes a 3-bit register model: control {group req, group en, global en}
// and one source-flag bit per event input.
package grp_irq_pkg;
    localparam int         AMP_CNT_DEF  = 2;
    localparam int         SYNC_DEF     = 2;
    localparam int         VEC_W_DEF    = 8;
    localparam logic [7:0] SVC_VEC_DEF  = 8'h18;

    // Bit positions within the control register
    localparam int CTL_GIE   = 0;
    localparam int CTL_GEN   = 1;
    localparam int CTL_GREQ  = 2;
    localparam int CTL_BITS  = 3;

    // Register select codes
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_SRC  = 1'b1;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_kind_e;
endpackage

// File: rtl/irq_src_detect.sv
// Synchronizes one asynchronous event input and flags a selected edge kind.
// Assumes SYNC_STAGES >= 2. The event is a one-cycle pulse, valid the cycle
// after the synchronized value changes relative to its registered copy.
module irq_src_detect
    import grp_irq_pkg::*;
#(
    parameter int         SYNC_STAGES = SYNC_DEF,
    parameter edge_kind_e KIND        = EDGE_FALL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;
    logic         cur;

    // Shift the input through the synchronizer and keep the previous value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[TOP-1:0], din};
            last_q <= sync_q[TOP];
        end
    end

    assign cur = sync_q[TOP];

    // Select the edge comparison for the configured kind
    generate
        if (KIND == EDGE_FALL) begin : g_fall
            assign evt = last_q & ~cur;
        end else if (KIND == EDGE_RISE) begin : g_rise
            assign evt = ~last_q & cur;
        end else begin : g_both
            assign evt = last_q ^ cur;
        end
    endgenerate
endmodule

// File: rtl/irq_flag_bank.sv
// Per-source pending flags. Software writes load the whole bank;
// hardware events OR in afterwards so that a set wins over a clear.
// Servicing has no effect here.
module irq_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         wr_en,
    input  logic [N-1:0] wr_data,
    output logic [N-1:0] flags
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            // One flop per source: load on write, then apply the hardware set
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else begin
                    flags[i] <= (wr_en ? wr_data[i] : flags[i]) | evt[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irq_svc_ctrl.sv
// Holds the global enable, group enable and group request, and decides
// on the vectored call. Assumes stack_full is registered by its driver.
// The service clear overrides a software write; a hardware event
// overrides both for the group request.
module irq_svc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic any_evt,
    input  logic wr_en,
    input  logic wr_gie,
    input  logic wr_gen,
    input  logic wr_greq,
    input  logic stack_full,
    output logic gie,
    output logic gen,
    output logic greq,
    output logic call_req
);
    logic take;
    logic gie_d;
    logic gen_d;
    logic greq_d;

    // Call decision: every condition is sampled in the same cycle
    assign take = gie & gen & greq & ~stack_full;

    // Next-state priority: write, then service clear, then hardware set
    always_comb begin
        gie_d  = wr_en ? wr_gie  : gie;
        gen_d  = wr_en ? wr_gen  : gen;
        greq_d = wr_en ? wr_greq : greq;
        if (take) begin
            gie_d  = 1'b0;
            greq_d = 1'b0;
        end
        greq_d = greq_d | any_evt;
    end

    // Register the enables, the request and the one-cycle call strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie      <= 1'b0;
            gen      <= 1'b0;
            greq     <= 1'b0;
            call_req <= 1'b0;
        end else begin
            gie      <= gie_d;
            gen      <= gen_d;
            greq     <= greq_d;
            call_req <= take;
        end
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
// Top of the grouped interrupt controller. It instantiates one falling-edge
// detector per amplifier input and a both-edge detector for the comparator,
// the source flag bank and the service controller. It also provides the
// register read mux and the wake output. Inputs are asynchronous.
module grp_irq_ctrl
    import grp_irq_pkg::*;
#(
    parameter int         NUM_AMP  = AMP_CNT_DEF,
    parameter int         SYNC_LEN = SYNC_DEF,
    parameter int         VEC_W    = VEC_W_DEF,
    parameter logic [7:0] SVC_VEC  = SVC_VEC_DEF,
    localparam int        NUM_SRC  = NUM_AMP + 1,
    localparam int        REG_W    = (NUM_SRC > CTL_BITS) ? NUM_SRC : CTL_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_AMP-1:0] amp_in,
    input  logic               cmp_in,
    input  logic               stack_full,
    input  logic               sleep_mode,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               call_req,
    output logic [VEC_W-1:0]   call_vec,
    output logic               wake
);
    logic [NUM_SRC-1:0] src_evt;
    logic [NUM_SRC-1:0] src_flags;
    logic               gie;
    logic               gen;
    logic               greq;
    logic               wr_ctrl;
    logic               wr_src;

    genvar k;
    generate
        for (k = 0; k < NUM_AMP; k++) begin : g_amp
            irq_src_detect #(
                .SYNC_STAGES (SYNC_LEN),
                .KIND        (EDGE_FALL)
            ) u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (amp_in[k]),
                .evt   (src_evt[k])
            );
        end
    endgenerate

    irq_src_detect #(
        .SYNC_STAGES (SYNC_LEN),
        .KIND        (EDGE_BOTH)
    ) u_cmp_det (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_in),
        .evt   (src_evt[NUM_SRC-1])
    );

    assign wr_ctrl = reg_we & (reg_addr == SEL_CTRL);
    assign wr_src  = reg_we & (reg_addr == SEL_SRC);

    irq_flag_bank #(
        .N (NUM_SRC)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (src_evt),
        .wr_en   (wr_src),
        .wr_data (reg_wdata[NUM_SRC-1:0]),
        .flags   (src_flags)
    );

    irq_svc_ctrl u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_evt    (|src_evt),
        .wr_en      (wr_ctrl),
        .wr_gie     (reg_wdata[CTL_GIE]),
        .wr_gen     (reg_wdata[CTL_GEN]),
        .wr_greq    (reg_wdata[CTL_GREQ]),
        .stack_full (stack_full),
        .gie        (gie),
        .gen        (gen),
        .greq       (greq),
        .call_req   (call_req)
    );

    // Read mux: zero-extend whichever register is selected
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == SEL_CTRL) begin
            reg_rdata[CTL_GIE]  = gie;
            reg_rdata[CTL_GEN]  = gen;
            reg_rdata[CTL_GREQ] = greq;
        end else begin
            reg_rdata[NUM_SRC-1:0] = src_flags;
        end
    end

    assign call_vec = VEC_W'(SVC_VEC);

    // Wake whenever anything is pending while the core sleeps
    assign wake = sleep_mode & (greq | (|src_flags));
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
// Temporal checks on the grouped interrupt controller, bound into the top.
module grp_irq_ctrl_chk #(
    parameter int NUM_SRC = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               call_req,
    input logic               stack_full,
    input logic               sleep_mode,
    input logic               wake,
    input logic               gie,
    input logic               gen,
    input logic               greq,
    input logic               wr_ctrl,
    input logic               wr_src,
    input logic [NUM_SRC-1:0] src_flags
);
    // R4
    call_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> $past(gie && gen && greq && !stack_full));

    // R6
    call_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> !call_req);

    // R6
    gie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> !gie);

    // R7
    src_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !$past(wr_src)) |-> ((src_flags & $past(src_flags)) == $past(src_flags)));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (greq && !gen && !wr_ctrl) |=> greq);

    // R9
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode && (greq || (|src_flags))) |-> wake);
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_req   (call_req),
    .stack_full (stack_full),
    .sleep_mode (sleep_mode),
    .wake       (wake),
    .gie        (gie),
    .gen        (gen),
    .greq       (greq),
    .wr_ctrl    (wr_ctrl),
    .wr_src     (wr_src),
    .src_flags  (src_flags)
);

// File: tb/grp_irq_ctrl_bench.sv
`timescale 1ns/1ps
module grp_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] amp_in = 2'b00;
    logic       cmp_in = 1'b0;
    logic       stack_full = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [2:0] reg_wdata = 3'b000;
    logic [2:0] reg_rdata;
    logic       call_req;
    logic [7:0] call_vec;
    logic       wake;

    int checks = 0;
    int errors = 0;
    int calls  = 0;
    logic [7:0] last_vec = 8'h00;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    grp_irq_ctrl u_grp_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .amp_in     (amp_in),
        .cmp_in     (cmp_in),
        .stack_full (stack_full),
        .sleep_mode (sleep_mode),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .call_req   (call_req),
        .call_vec   (call_vec),
        .wake       (wake)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: input history and architectural state
    logic [2:0] m_s1 = 0, m_s2 = 0, m_prev = 0, m_src = 0, ev;
    logic       m_gie = 0, m_gen = 0, m_greq = 0, m_call = 0, take;
    logic [2:0] exp_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_src = 0;
            m_gie = 0; m_gen = 0; m_greq = 0; m_call = 0;
        end else begin
            for (int i = 0; i < 2; i++) ev[i] = m_prev[i] & ~m_s2[i];
            ev[2] = m_prev[2] ^ m_s2[2];
            take = m_gie & m_gen & m_greq & ~stack_full;
            if (reg_we && reg_addr == 1'b0) begin
                m_gie = reg_wdata[0]; m_gen = reg_wdata[1]; m_greq = reg_wdata[2];
            end
            if (reg_we && reg_addr == 1'b1) m_src = reg_wdata;
            if (take) begin m_gie = 0; m_greq = 0; end
            m_src = m_src | ev;
            if (ev != 0) m_greq = 1;
            m_call = take;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = {cmp_in, amp_in};
        end
        #1;
        exp_rd = (reg_addr == 1'b0) ? {m_greq, m_gen, m_gie} : m_src;
        check(reg_addr ? "R1/R3 src register model" : "R11 ctrl register model", reg_rdata, exp_rd);
        check("R4 call_req model", call_req, m_call);
        check("R9 wake model", wake, sleep_mode & (m_greq | (|m_src)));
        if (call_req) begin
            calls++;
            last_vec = call_vec;
            check("R5 call vector", call_vec, 8'h18);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [2:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic a, input logic [2:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        #1;
        check(req, reg_rdata, exp);
    endtask

    int c0;

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R11 reset values
        rd_chk(1'b0, 3'b000, "R11 ctrl reset");
        rd_chk(1'b1, 3'b000, "R11 src reset");
        // R2 rising amplifier edge ignored
        @(negedge clk); amp_in = 2'b11;
        tick(5);
        rd_chk(1'b1, 3'b000, "R2 rising edge sets nothing");
        rd_chk(1'b0, 3'b000, "R2 no group request");
        // R1 falling edge on amplifier 0
        @(negedge clk); amp_in = 2'b10;
        tick(5);
        rd_chk(1'b1, 3'b001, "R1 amp0 flag");
        rd_chk(1'b0, 3'b100, "R1 group request");
        // R9 wake while sleeping
        @(negedge clk); sleep_mode = 1'b1;
        @(posedge clk); #1;
        check("R9 wake asserted", wake, 1);
        @(negedge clk); sleep_mode = 1'b0;
        // R8 pending held with enables off, then serviced
        c0 = calls;
        tick(6);
        check("R8 no call while disabled", calls, c0);
        wr(1'b0, 3'b111);
        tick(4);
        check("R8 serviced once enabled", calls, c0 + 1);
        check("R5 vector 0x18", last_vec, 8'h18);
        tick(4);
        check("R6 single pulse", calls, c0 + 1);
        rd_chk(1'b0, 3'b010, "R6 request and global enable cleared");
        rd_chk(1'b1, 3'b001, "R7 source flag kept after call");
        // R4 blocked by full stack; R3 comparator rising edge
        @(negedge clk); stack_full = 1'b1; cmp_in = 1'b1;
        tick(5);
        rd_chk(1'b1, 3'b101, "R3 comparator rise");
        c0 = calls;
        wr(1'b0, 3'b111);
        tick(6);
        check("R4 no call with stack full", calls, c0);
        @(negedge clk); stack_full = 1'b0;
        tick(4);
        check("R4 call after stack frees", calls, c0 + 1);
        rd_chk(1'b1, 3'b101, "R7 flags persist after call");
        // R7 software clear, R3 comparator falling edge
        wr(1'b1, 3'b000);
        rd_chk(1'b1, 3'b000, "R7 software clear");
        @(negedge clk); cmp_in = 1'b0;
        tick(5);
        rd_chk(1'b1, 3'b100, "R3 comparator fall");
        // R4 group enable off blocks the call
        c0 = calls;
        wr(1'b0, 3'b101);
        tick(5);
        check("R4 no call without group enable", calls, c0);
        rd_chk(1'b0, 3'b101, "R8 request held");
        wr(1'b0, 3'b111);
        tick(4);
        check("R8 call after group enable", calls, c0 + 1);
        // R10 write clear coinciding with hardware set
        wr(1'b1, 3'b000);
        @(negedge clk); amp_in = 2'b00;   // amplifier 1 falls
        @(negedge clk);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 3'b000;
        @(negedge clk); reg_we = 1'b0;
        rd_chk(1'b1, 3'b010, "R10 hardware set wins");
        tick(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule